// File: doc/BRIEF.md
# TDC Calibration Pulse Sequencer

This block produces pairs of timing pulses for calibrating time-to-digital converters. Each pair is one START pulse, which a common fan-out carries to every converter channel, followed by one STOP pulse. The separation between the two is a whole number of periods of a reference clock that the host picks. Six reference rates are modelled as enable ticks divided down from one fast system clock: 40, 32, 25, 20, 16 and 10 MHz.

A sweep begins when the host pulses a go command while the block is idle. The block then copies the host settings into its own registers: the reference select, the sample count N, the idle gap G and the maximum delay M. The first N pairs are one reference period apart. The next N pairs are two periods apart, and so on, until N pairs at M periods have been produced. A busy level covers the whole sweep. A one-cycle done pulse closes it.

All six reference dividers are reset to phase zero on every START. Each STOP therefore lands exactly d × DIV system cycles after its START, where DIV is the system-to-reference ratio.

Top module: `tdc_cal_sequencer`

## Requirements
- R1: Directly after reset, busy, done, start_pulse and stop_pulse are all low.
- R2: A go command seen while busy is low produces start_pulse in the next cycle, and busy is high in that same cycle.
- R3: The system cycles from a START to its STOP equal d × DIV. d is the current delay step and DIV = SYS_MHZ / f. Select codes 0, 1, 2, 3, 4 and 5 choose f = 40, 32, 25, 20, 16 and 10 MHz, so with SYS_MHZ = 800 the values of DIV are 20, 25, 32, 40, 50 and 80.
- R4: Select codes 6 and 7 behave as code 5, giving DIV = 80 at SYS_MHZ = 800.
- R5: The delay step begins at 1. It holds for N consecutive pairs and then rises by one, ending after the N pairs at step M, for N × M pairs in total. A programmed N or M of zero counts as one.
- R6: Between two pairs of one sweep, the next START comes exactly G + 1 cycles after the previous STOP.
- R7: done is high for exactly one cycle, in the cycle after the last STOP, and busy is low in that cycle. No gap follows the last pair.
- R8: While busy is high, the go input and all settings inputs are ignored. The sweep follows the settings captured at its go. A go in the done cycle starts a new sweep.
- R9: start_pulse and stop_pulse are each high for single cycles only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_refsel | input | 3 | Reference rate select, codes 0 to 5, with 6 and 7 folded to 5 |
| cfg_samples | input | SAMP_W | Pairs per delay step (N) |
| cfg_gap | input | GAP_W | Idle cycles between a STOP and the next START (G) |
| cfg_maxdly | input | DLY_W | Last delay step in reference periods (M) |
| cmd_go | input | 1 | Launch a sweep, sampled each cycle |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep flag |
| start_pulse | output | 1 | START pulse to the common fan-out |
| stop_pulse | output | 1 | STOP pulse |

## Verification
Two functions can land in the same cycle. One is a new go command. The other is the end of a sweep (the done cycle), or a STOP pulse in the middle of a sweep. The bench raises go in the very cycle of a predicted STOP and at the same time changes every settings input. It then judges the whole pulse train against the settings captured originally, so the go must have been ignored. The bench also raises go in the cycle in which done is seen. It requires the next sweep's first START to come one cycle later, with no dead cycle between the two sweeps.

// File: rtl/tdccal_pkg.sv
package tdccal_pkg;

    localparam int NUM_REF = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEAS = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_e;

    // reference rate in MHz for each legal select code
    function automatic int ref_mhz(input int idx);
        case (idx)
            0:       return 40;
            1:       return 32;
            2:       return 25;
            3:       return 20;
            4:       return 16;
            default: return 10;
        endcase
    endfunction

    function automatic int ref_div(input int sys_mhz, input int idx);
        return sys_mhz / ref_mhz(idx);
    endfunction

    // codes above the last legal one use the slowest rate
    function automatic logic [2:0] sel_fold(input logic [2:0] code);
        return (code > 3'd5) ? 3'd5 : code;
    endfunction

endpackage

// File: rtl/refdiv_bank.sv
module refdiv_bank
    import tdccal_pkg::*;
#(
    parameter int SYS_MHZ = 800
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    output logic [NUM_REF-1:0] ticks
);

    for (genvar g = 0; g < NUM_REF; g++) begin : g_div
        localparam int DIV = ref_div(SYS_MHZ, g);
        localparam int CW  = (DIV > 2) ? $clog2(DIV) : 1;
        localparam logic [CW-1:0] LAST = CW'(DIV - 1);

        logic [CW-1:0] cnt_d, cnt_q;

        always_comb begin
            if (clr) begin
                cnt_d = '0;
            end else if (cnt_q == LAST) begin
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_d;
            end
        end

        assign ticks[g] = (cnt_q == LAST);

        // R3: a re-phased divider cannot tick in the cycle right after the clear
        a_r3_no_tick_after_clr: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> !ticks[g]);
    end

endmodule

// File: rtl/tick_select.sv
module tick_select
    import tdccal_pkg::*;
(
    input  logic [NUM_REF-1:0] ticks,
    input  logic [2:0]         sel,
    output logic               tick
);

    always_comb begin
        case (sel)
            3'd0:    tick = ticks[0];
            3'd1:    tick = ticks[1];
            3'd2:    tick = ticks[2];
            3'd3:    tick = ticks[3];
            3'd4:    tick = ticks[4];
            default: tick = ticks[5];
        endcase
    end

endmodule

// File: rtl/cal_seq_fsm.sv
module cal_seq_fsm
    import tdccal_pkg::*;
#(
    parameter int SAMP_W = 8,
    parameter int GAP_W  = 8,
    parameter int DLY_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_refsel,
    input  logic [SAMP_W-1:0] cfg_samples,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic [DLY_W-1:0]  cfg_maxdly,
    input  logic              cmd_go,
    input  logic              tick,
    output logic [2:0]        sel_q,
    output logic              div_clr,
    output logic              busy,
    output logic              done,
    output logic              start_pulse,
    output logic              stop_pulse
);

    typedef struct packed {
        seq_state_e        st;
        logic [2:0]        sel;
        logic [SAMP_W-1:0] nsamp;
        logic [GAP_W-1:0]  gap;
        logic [DLY_W-1:0]  maxd;
        logic [DLY_W-1:0]  dly;
        logic [DLY_W-1:0]  tcnt;
        logic [SAMP_W-1:0] sidx;
        logic [GAP_W-1:0]  gcnt;
        logic              last;
        logic              start;
        logic              stop;
        logic              done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        r_d.stop  = 1'b0;
        r_d.done  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (cmd_go) begin
                    r_d.st    = ST_MEAS;
                    r_d.sel   = sel_fold(cfg_refsel);
                    r_d.nsamp = (cfg_samples == '0) ? SAMP_W'(1) : cfg_samples;
                    r_d.gap   = cfg_gap;
                    r_d.maxd  = (cfg_maxdly == '0) ? DLY_W'(1) : cfg_maxdly;
                    r_d.dly   = DLY_W'(1);
                    r_d.tcnt  = '0;
                    r_d.sidx  = '0;
                    r_d.gcnt  = '0;
                    r_d.last  = 1'b0;
                    r_d.start = 1'b1;
                end
            end
            ST_MEAS: begin
                if (tick) begin
                    if (r_q.tcnt + DLY_W'(1) == r_q.dly) begin
                        r_d.stop = 1'b1;
                        r_d.st   = ST_GAP;
                        r_d.tcnt = '0;
                        r_d.gcnt = '0;
                        if (r_q.sidx + SAMP_W'(1) == r_q.nsamp) begin
                            r_d.sidx = '0;
                            if (r_q.dly == r_q.maxd) begin
                                r_d.last = 1'b1;
                            end else begin
                                r_d.dly = r_q.dly + DLY_W'(1);
                            end
                        end else begin
                            r_d.sidx = r_q.sidx + SAMP_W'(1);
                        end
                    end else begin
                        r_d.tcnt = r_q.tcnt + DLY_W'(1);
                    end
                end
            end
            ST_GAP: begin
                if (r_q.last) begin
                    r_d.st   = ST_IDLE;
                    r_d.last = 1'b0;
                    r_d.done = 1'b1;
                end else if (r_q.gcnt == r_q.gap) begin
                    r_d.st    = ST_MEAS;
                    r_d.tcnt  = '0;
                    r_d.start = 1'b1;
                end else begin
                    r_d.gcnt = r_q.gcnt + GAP_W'(1);
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sel_q       = r_q.sel;
    assign div_clr     = r_d.start;
    assign busy        = (r_q.st != ST_IDLE);
    assign done        = r_q.done;
    assign start_pulse = r_q.start;
    assign stop_pulse  = r_q.stop;

    // R2: an accepted go yields START and busy one cycle later
    a_r2_go_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_go) |=> (start_pulse && busy));

    // R5: the active delay step stays within 1..M during a sweep
    a_r5_dly_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (r_q.dly != '0 && r_q.dly <= r_q.maxd));

    // R7: done follows the last STOP and ends busy
    a_r7_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(stop_pulse) && !busy));

    // R7: done lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: captured settings hold for the whole sweep
    a_r8_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(r_q.sel) && $stable(r_q.nsamp)
                                   && $stable(r_q.gap) && $stable(r_q.maxd)));

    // R9: single-cycle pulses
    a_r9_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
    a_r9_stop_single: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse);

    // R4: the folded select never exceeds the last legal code
    a_r4_sel_folded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (sel_q <= 3'd5));

endmodule

// File: rtl/tdc_cal_sequencer.sv
module tdc_cal_sequencer
    import tdccal_pkg::*;
#(
    parameter int SYS_MHZ = 800,
    parameter int SAMP_W  = 8,
    parameter int GAP_W   = 8,
    parameter int DLY_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_refsel,
    input  logic [SAMP_W-1:0] cfg_samples,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic [DLY_W-1:0]  cfg_maxdly,
    input  logic              cmd_go,
    output logic              busy,
    output logic              done,
    output logic              start_pulse,
    output logic              stop_pulse
);

    logic [NUM_REF-1:0] ticks;
    logic [2:0]         sel_q;
    logic               tick;
    logic               div_clr;

    refdiv_bank #(
        .SYS_MHZ (SYS_MHZ)
    ) u_divs (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (div_clr),
        .ticks (ticks)
    );

    tick_select u_sel (
        .ticks (ticks),
        .sel   (sel_q),
        .tick  (tick)
    );

    cal_seq_fsm #(
        .SAMP_W (SAMP_W),
        .GAP_W  (GAP_W),
        .DLY_W  (DLY_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_refsel  (cfg_refsel),
        .cfg_samples (cfg_samples),
        .cfg_gap     (cfg_gap),
        .cfg_maxdly  (cfg_maxdly),
        .cmd_go      (cmd_go),
        .tick        (tick),
        .sel_q       (sel_q),
        .div_clr     (div_clr),
        .busy        (busy),
        .done        (done),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse)
    );

endmodule

// File: tb/tdc_cal_sequencer_tb_top.sv
`timescale 1ns/1ps
module tdc_cal_sequencer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_refsel = '0;
    logic [7:0] cfg_samples = '0;
    logic [7:0] cfg_gap = '0;
    logic [7:0] cfg_maxdly = '0;
    logic       cmd_go = 1'b0;
    logic       busy, done, start_pulse, stop_pulse;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    int st_c [1024];
    int sp_c [1024];
    int dn_c [64];
    bit dn_busy [64];
    int ns = 0, np = 0, nd = 0;
    int wide = 0;
    bit prev_st = 0, prev_sp = 0, prev_dn = 0;

    tdc_cal_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_refsel(cfg_refsel), .cfg_samples(cfg_samples),
        .cfg_gap(cfg_gap), .cfg_maxdly(cfg_maxdly), .cmd_go(cmd_go),
        .busy(busy), .done(done), .start_pulse(start_pulse), .stop_pulse(stop_pulse)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (start_pulse && ns < 1024) begin st_c[ns] = cyc; ns++; end
        if (stop_pulse && np < 1024) begin sp_c[np] = cyc; np++; end
        if (done && nd < 64) begin dn_c[nd] = cyc; dn_busy[nd] = busy; nd++; end
        if ((start_pulse && prev_st) || (stop_pulse && prev_sp) || (done && prev_dn)) wide++;
        prev_st = start_pulse; prev_sp = stop_pulse; prev_dn = done;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_div(input int sel);
        int f;
        case (sel)
            0: f = 40; 1: f = 32; 2: f = 25; 3: f = 20; 4: f = 16;
            default: f = 10;
        endcase
        return 800 / f;
    endfunction

    task automatic run_case(input int sel, input int n, input int m, input int g,
                            input bit inject, input bit chain);
        int go_cyc, b_s, b_p, b_d, dv, neff, meff, total, guard;
        if (!chain) begin @(negedge clk); #1; end
        cfg_refsel = 3'(sel); cfg_samples = 8'(n); cfg_gap = 8'(g); cfg_maxdly = 8'(m);
        cmd_go = 1'b1;
        go_cyc = cyc;
        b_s = ns; b_p = np; b_d = nd;
        dv = exp_div(sel);
        neff = (n == 0) ? 1 : n;
        meff = (m == 0) ? 1 : m;
        total = neff * meff;
        @(negedge clk); #1;
        cmd_go = 1'b0;
        chk(start_pulse && busy, "R2 start+busy after go", {30'd0, start_pulse, busy}, 3);
        if (inject) begin
            while (cyc < go_cyc + 1 + dv) begin @(negedge clk); #1; end
            // R8: go and new settings during the first STOP cycle
            cmd_go = 1'b1;
            cfg_refsel = 3'((sel + 3) % 8); cfg_samples = 8'(n + 2);
            cfg_gap = 8'(g + 4); cfg_maxdly = 8'(m + 1);
            @(negedge clk); #1;
            cmd_go = 1'b0;
        end
        guard = 0;
        while (nd == b_d && guard < 30000) begin @(negedge clk); #1; guard++; end
        if (guard >= 30000) begin
            chk(0, "R7 watchdog waiting for done", guard, 0);
            return;
        end
        chk(ns - b_s == total, "R5 START count", ns - b_s, total);
        chk(np - b_p == total, "R5 STOP count", np - b_p, total);
        chk(st_c[b_s] == go_cyc + 1, "R2 first START cycle", st_c[b_s], go_cyc + 1);
        for (int k = 0; k < total && (b_s + k) < ns && (b_p + k) < np; k++) begin
            int d, act;
            d = k / neff + 1;
            act = sp_c[b_p + k] - st_c[b_s + k];
            if (sel > 5) chk(act == d * dv, "R4 START-STOP spacing", act, d * dv);
            else         chk(act == d * dv, "R3 START-STOP spacing", act, d * dv);
            if (k + 1 < total && (b_s + k + 1) < ns) begin
                act = st_c[b_s + k + 1] - sp_c[b_p + k];
                chk(act == g + 1, "R6 STOP-START gap", act, g + 1);
            end
        end
        chk(nd - b_d == 1, "R7 done count", nd - b_d, 1);
        chk(dn_c[b_d] == sp_c[np - 1] + 1, "R7 done cycle", dn_c[b_d], sp_c[np - 1] + 1);
        chk(dn_busy[b_d] == 1'b0, "R7 busy low with done", int'(dn_busy[b_d]), 0);
        if (inject) chk(ns - b_s == total, "R8 ignored go left sweep intact", ns - b_s, total);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(20240611);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk({busy, done, start_pulse, stop_pulse} == 4'b0, "R1 outputs in reset",
            {busy, done, start_pulse, stop_pulse}, 0);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk({busy, done, start_pulse, stop_pulse} == 4'b0, "R1 outputs after reset",
            {busy, done, start_pulse, stop_pulse}, 0);

        run_case(0, 2, 3, 1, 0, 0);
        run_case(6, 1, 2, 0, 0, 0);
        run_case(7, 0, 0, 3, 0, 0);
        run_case(5, 3, 2, 5, 1, 0);
        run_case(2, 1, 1, 0, 0, 1);   // R8: go in the done cycle
        run_case(1, 2, 2, 2, 0, 1);
        for (int i = 0; i < 8; i++) begin
            int s, n, m, g;
            bit ch;
            s = int'($urandom_range(0, 7));
            n = int'($urandom_range(0, 3));
            m = int'($urandom_range(0, 4));
            g = int'($urandom_range(0, 7));
            ch = 1'($urandom_range(0, 1));
            run_case(s, n, m, g, (i == 3), ch);
        end
        repeat (3) @(negedge clk);
        chk(wide == 0, "R9 single-cycle pulses", wide, 0);
        chk(!busy && !done, "R7 idle after sweeps", {30'd0, busy, done}, 0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule